// File: doc/BRIEF.md
# CAN Bit Stuffing Encoder and Decoder

This block holds the two halves of the bit-stuffing layer for a CAN-style NRZ link. The transmit half takes one data bit at a time from a source over a valid/ready handshake and drives the line bit. Whenever the stuffed region has produced a run of `RUN_LIMIT` equal levels (five by default), it inserts one bit of the opposite level. The receive half samples the line, counts equal levels and removes the inserted bits. If a run is one bit longer than the limit, it raises a stuff error and delivers no data bit.

Both halves move only on `bit_tick`, a one-cycle strobe at the sample point of each bit time. Each half has its own stuffing-enable input. The framer holds that input high for fields that are stuffed and low for fixed-form fields such as the CRC delimiter, the acknowledge slot, end of frame, and error or overload frames. Logic 0 is the dominant level and logic 1 is the recessive level, and the idle line is recessive.

Back-pressure rules: `src_ready` is high only in a cycle where `bit_tick` is high and no stuff bit is due. A bit is taken when `src_valid` and `src_ready` are both high in the same cycle. The source must present its next bit before every tick inside a frame, because a tick with `src_valid` low is treated as idle. The receive side has no back-pressure: every delivered bit appears as a one-cycle `rx_valid` pulse, and the consumer must take it in that cycle.

Top module: `can_stuff_codec`

## Requirements
- R1: During and after reset, before any tick, `line_tx` is 1, `src_ready` is 0, `rx_valid` is 0 and `rx_stuff_err` is 0.
- R2: `src_ready` is high only in a cycle with `bit_tick` high and no stuff bit due. An accepted bit appears on `line_tx` one clock after the accepting edge.
- R3: After `RUN_LIMIT` consecutive equal stuffed line bits, the next tick drives the complement level on `line_tx`, and `src_ready` is low in that tick cycle. The data bit that was offered is sent on a later tick.
- R4: An inserted stuff bit counts as the first bit of the next run. With stuffing, data 0,0,0,0,0 followed by 1,1,1,1,1 is sent as 0,0,0,0,0,1,1,1,1,1,0,1.
- R5: A bit accepted while `tx_stuff_en` is low is sent unstuffed and clears the run count, and counting restarts at the next bit accepted with stuffing on. A stuff bit that is already due is still sent first, even if enable has dropped.
- R6: A tick with `src_valid` low drives recessive 1 on `line_tx` and clears the run count, unless a stuff bit is due.
- R7: For each ticked line bit that is not a stuff position, the receiver pulses `rx_valid` for one cycle, one clock after the tick edge, with `rx_bit` equal to the sampled level.
- R8: After `RUN_LIMIT` equal line bits, a following bit of the opposite level is removed without an `rx_valid` pulse, and it counts as the first bit of the next run.
- R9: After `RUN_LIMIT` equal line bits, a following bit of the same level pulses `rx_stuff_err` for one cycle, gives no `rx_valid`, and clears the run count.
- R10: A bit received while `rx_stuff_en` is low, and not at a stuff position, is delivered and clears the run count. Any number of equal bits then passes with no drop and no error.
- R11: Without `bit_tick`, `line_tx` holds its value, `src_ready` stays low and `rx_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe, one per bit time |
| tx_stuff_en | input | 1 | The offered transmit bit lies in the stuffed region |
| src_valid | input | 1 | Source offers a data bit |
| src_bit | input | 1 | Offered data bit |
| src_ready | output | 1 | Offered bit is taken this cycle |
| line_tx | output | 1 | Transmit line level (0 dominant) |
| rx_stuff_en | input | 1 | The sampled receive bit lies in the stuffed region |
| line_rx | input | 1 | Receive line level sampled on the tick |
| rx_valid | output | 1 | Pulse marking a delivered data bit |
| rx_bit | output | 1 | Delivered data bit |
| rx_stuff_err | output | 1 | Pulse marking a run longer than the limit |

## Verification
Two situations fall in the same cycle. In the first, a stuff bit comes due on the same tick that the source offers its next bit. In the second, the enable drops on the tick where a stuff bit is pending. The bench covers the first by sweeping every 10-bit pattern through the transmitter, with the line looped back into the receiver one tick later. An arithmetic run model predicts `src_ready` and the line level on each tick and the receiver outcome for each looped bit. It covers the second with a directed sequence that lowers `tx_stuff_en` right after five zeros and expects a 1 stuff bit with `src_ready` low before the unstuffed 0 goes out. For the receiver, a sixth equal bit must produce an error pulse and no data pulse, and a bit of the opposite level at the same position must vanish silently.

// File: rtl/can_stuff_pkg.sv
`timescale 1ns/1ps
package can_stuff_pkg;

  // Transmit action taken on a tick
  typedef enum logic [1:0] {
    TXA_IDLE  = 2'd0,
    TXA_DATA  = 2'd1,
    TXA_STUFF = 2'd2
  } tx_act_e;

  // Receive outcome of a sampled bit
  typedef enum logic [1:0] {
    RXA_DATA  = 2'd0,
    RXA_DROP  = 2'd1,
    RXA_FAULT = 2'd2
  } rx_act_e;

  function automatic int unsigned run_width(input int unsigned limit);
    return $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/can_run_tracker.sv
`timescale 1ns/1ps
module can_run_tracker #(
  parameter int unsigned RUN_LIMIT = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  input  logic bit_in,
  output logic last_bit,
  output logic at_limit
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LIMIT);

  logic [CNT_W-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len  <= '0;
      last_bit <= 1'b1;
    end else if (step) begin
      last_bit <= bit_in;
      if (clear)
        run_len <= '0;
      else if (run_len != '0 && bit_in == last_bit)
        run_len <= run_len + 1'b1;
      else
        run_len <= CNT_W'(1);
    end
  end

  assign at_limit = (run_len == LIM);
endmodule

// File: rtl/can_stuff_tx.sv
`timescale 1ns/1ps
module can_stuff_tx
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic stuff_en,
  input  logic src_valid,
  input  logic src_bit,
  output logic src_ready,
  output logic line_tx
);
  tx_act_e act;
  logic    last_bit, at_limit, next_bit, clr;

  always_comb begin
    if (at_limit)       act = TXA_STUFF;
    else if (src_valid) act = TXA_DATA;
    else                act = TXA_IDLE;
  end

  always_comb begin
    unique case (act)
      TXA_STUFF: next_bit = ~last_bit;
      TXA_DATA:  next_bit = src_bit;
      default:   next_bit = 1'b1;
    endcase
  end

  assign clr       = (act == TXA_IDLE) || (act == TXA_DATA && !stuff_en);
  assign src_ready = bit_tick && !at_limit;

  can_run_tracker #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (bit_tick),
    .clear    (clr),
    .bit_in   (next_bit),
    .last_bit (last_bit),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        line_tx <= 1'b1;
    else if (bit_tick) line_tx <= next_bit;
  end
endmodule

// File: rtl/can_destuff_rx.sv
`timescale 1ns/1ps
module can_destuff_rx
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic stuff_en,
  input  logic line_rx,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_stuff_err
);
  rx_act_e act;
  logic    last_bit, at_limit, clr;

  always_comb begin
    if (!at_limit)               act = RXA_DATA;
    else if (line_rx == last_bit) act = RXA_FAULT;
    else                         act = RXA_DROP;
  end

  assign clr = (act == RXA_FAULT) || (act == RXA_DATA && !stuff_en);

  can_run_tracker #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (bit_tick),
    .clear    (clr),
    .bit_in   (line_rx),
    .last_bit (last_bit),
    .at_limit (at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid     <= 1'b0;
      rx_bit       <= 1'b1;
      rx_stuff_err <= 1'b0;
    end else begin
      rx_valid     <= bit_tick && (act == RXA_DATA);
      rx_stuff_err <= bit_tick && (act == RXA_FAULT);
      if (bit_tick) rx_bit <= line_rx;
    end
  end
endmodule

// File: rtl/can_stuff_codec.sv
`timescale 1ns/1ps
module can_stuff_codec
  import can_stuff_pkg::*;
#(
  parameter int unsigned RUN_LIMIT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_stuff_en,
  input  logic src_valid,
  input  logic src_bit,
  output logic src_ready,
  output logic line_tx,
  input  logic rx_stuff_en,
  input  logic line_rx,
  output logic rx_valid,
  output logic rx_bit,
  output logic rx_stuff_err
);
  localparam int unsigned CNT_W = run_width(RUN_LIMIT);

  can_stuff_tx #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .stuff_en  (tx_stuff_en),
    .src_valid (src_valid),
    .src_bit   (src_bit),
    .src_ready (src_ready),
    .line_tx   (line_tx)
  );

  can_destuff_rx #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .stuff_en     (rx_stuff_en),
    .line_rx      (line_rx),
    .rx_valid     (rx_valid),
    .rx_bit       (rx_bit),
    .rx_stuff_err (rx_stuff_err)
  );
endmodule

// File: rtl/can_stuff_codec_chk.sv
`timescale 1ns/1ps
module can_stuff_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic src_valid,
  input logic src_ready,
  input logic line_tx,
  input logic rx_valid,
  input logic rx_stuff_err
);
  assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> bit_tick);

  assert_stuff_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !src_ready) |=> (line_tx != $past(line_tx)));

  assert_idle_recessive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && src_ready && !src_valid) |=> line_tx);

  assert_valid_after_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bit_tick));

  assert_err_excludes_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_stuff_err));

  assert_line_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(line_tx));
endmodule

bind can_stuff_codec can_stuff_codec_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .src_valid    (src_valid),
  .src_ready    (src_ready),
  .line_tx      (line_tx),
  .rx_valid     (rx_valid),
  .rx_stuff_err (rx_stuff_err)
);

// File: tb/can_stuff_codec_test.sv
`timescale 1ns/1ps
module can_stuff_codec_test;
  localparam int LIM = 5;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic tx_stuff_en = 1'b0, src_valid = 1'b0, src_bit = 1'b0;
  logic rx_stuff_en = 1'b0, line_rx = 1'b1;
  logic src_ready, line_tx, rx_valid, rx_bit, rx_stuff_err;

  int checks = 0, failures = 0;
  logic s_rdy, s_line, s_rv, s_rb, s_err;

  // transmit run model
  int   mrun = 0;
  logic mlast = 1'b1;
  // loopback: 0 idle, 1 data, 2 stuff
  int   prev_kind = 0;
  logic prev_line = 1'b1, prev_en = 1'b0;
  int   tx_bad, rx_bad;

  always #10 clk = ~clk;

  can_stuff_codec #(.RUN_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_stuff_en(tx_stuff_en),
    .src_valid(src_valid), .src_bit(src_bit), .src_ready(src_ready), .line_tx(line_tx),
    .rx_stuff_en(rx_stuff_en), .line_rx(line_rx), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .rx_stuff_err(rx_stuff_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic b, input logic ten,
                      input logic lr, input logic ren);
    @(negedge clk);
    src_valid = v; src_bit = b; tx_stuff_en = ten;
    line_rx = lr; rx_stuff_en = ren; bit_tick = 1'b1;
    #1 s_rdy = src_ready;
    @(negedge clk);
    bit_tick = 1'b0;
    s_line = line_tx; s_rv = rx_valid; s_rb = rx_bit; s_err = rx_stuff_err;
    @(negedge clk);
  endtask

  // One tick of the loopback sweep with model prediction
  task automatic sweep_step(input logic v, input logic b);
    logic exp_rdy, exp_line, new_en;
    int   kind;
    exp_rdy = (mrun != LIM);
    if (mrun == LIM) begin
      exp_line = ~mlast; mlast = ~mlast; mrun = 1; kind = 2; new_en = 1'b1;
    end else if (v) begin
      exp_line = b; kind = 1; new_en = 1'b1;
      mrun = (mrun != 0 && b == mlast) ? mrun + 1 : 1; mlast = b;
    end else begin
      exp_line = 1'b1; kind = 0; new_en = 1'b0; mrun = 0; mlast = 1'b1;
    end
    step(v, b, 1'b1, prev_line, prev_en);
    if (s_rdy !== exp_rdy || s_line !== exp_line) tx_bad++;
    if (prev_kind == 2) begin
      if (s_rv !== 1'b0 || s_err !== 1'b0) rx_bad++;
    end else begin
      if (s_rv !== 1'b1 || s_rb !== prev_line || s_err !== 1'b0) rx_bad++;
    end
    prev_kind = kind; prev_line = exp_line; prev_en = new_en;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_tx === 1'b1 && src_ready === 1'b0, "R1 tx reset", {line_tx, src_ready}, 2);
    chk(rx_valid === 1'b0 && rx_stuff_err === 1'b0, "R1 rx reset", {rx_valid, rx_stuff_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(line_tx === 1'b1 && src_ready === 1'b0, "R1 after release", {line_tx, src_ready}, 2);

    // Exhaustive sweep of 10-bit patterns, loopback delayed one tick
    for (int p = 0; p < 1024; p++) begin
      tx_bad = 0; rx_bad = 0;
      for (int i = 0; i < 10; i++) begin
        logic bb;
        bb = p[9-i];
        sweep_step(1'b1, bb);
        while (!s_rdy) sweep_step(1'b1, bb);
      end
      sweep_step(1'b0, 1'b0);
      sweep_step(1'b0, 1'b0);
      chk(tx_bad == 0, "R2 R3 R4 tx stream", tx_bad, 0);
      chk(rx_bad == 0, "R7 R8 rx recovery", rx_bad, 0);
    end
    sweep_step(1'b0, 1'b0);

    // R5: enable drops while stuff bit is due
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      chk(s_rdy === 1'b1 && s_line === 1'b0, "R5 stuffed zeros", {s_rdy, s_line}, 2);
    end
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(s_rdy === 1'b0 && s_line === 1'b1, "R5 pending stuff sent", {s_rdy, s_line}, 1);
    begin
      int bad = 0;
      for (int i = 0; i < 7; i++) begin
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        if (s_rdy !== 1'b1 || s_line !== 1'b0) bad++;
      end
      chk(bad == 0, "R5 unstuffed run", bad, 0);
    end
    for (int i = 0; i < 5; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      chk(s_rdy === 1'b1 && s_line === 1'b0, "R5 count restarts", {s_rdy, s_line}, 2);
    end
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(s_rdy === 1'b0 && s_line === 1'b1, "R3 stuff after restart", {s_rdy, s_line}, 1);
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(s_rdy === 1'b1 && s_line === 1'b1, "R6 idle recessive", {s_rdy, s_line}, 3);

    // R11: no tick, nothing moves
    begin
      int bad = 0;
      logic held;
      held = line_tx;
      src_valid = 1'b1; src_bit = 1'b0; tx_stuff_en = 1'b1; line_rx = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (src_ready !== 1'b0 || line_tx !== held || rx_valid !== 1'b0) bad++;
      end
      chk(bad == 0, "R11 quiet without tick", bad, 0);
    end

    // Receive: clean, then six zeros -> error
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      chk(s_rv === 1'b1 && s_rb === 1'b0 && s_err === 1'b0, "R7 rx zero delivered",
          {s_rv, s_rb, s_err}, 4);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(s_rv === 1'b0 && s_err === 1'b1, "R9 sixth equal bit", {s_rv, s_err}, 1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(s_rv === 1'b1 && s_rb === 1'b0 && s_err === 1'b0, "R9 count cleared",
        {s_rv, s_rb, s_err}, 4);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(s_rv === 1'b0 && s_err === 1'b0, "R8 stuff one removed", {s_rv, s_err}, 0);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      chk(s_rv === 1'b1 && s_rb === 1'b1, "R8 ones after stuff", {s_rv, s_rb}, 3);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(s_rv === 1'b0 && s_err === 1'b0, "R8 stuff bit counted in run", {s_rv, s_err}, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        if (s_rv !== 1'b1 || s_rb !== 1'b0 || s_err !== 1'b0) bad++;
      end
      chk(bad == 0, "R10 unstuffed rx run", bad, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule